// File: doc/BRIEF.md
# Guest-Aware Instruction Fault Classifier

This block sits beside the decode/execute stage of a RISC-V core that carries the hypervisor extension. For each instruction presented to it, it decides whether execution may go ahead, whether the instruction is an illegal-instruction fault (cause 2), or whether it is a virtual-instruction fault (cause 22). A virtual-instruction fault marks work that the hypervisor is expected to emulate for a guest. The decision depends on the guest bit, the privilege level, a pre-decoded instruction class, the CSR number of a CSR access, the machine and hypervisor counter-enable masks, and the trap-control bits held at machine level and hypervisor level.

A wait-for-interrupt held in the stage is timed by a cycle counter with a programmable limit. When the controlling bit is set and no enabled interrupt wakes the hart before the limit is reached, the wait turns into a fault. On any fault the value to be written to the trap-value CSR is the raw instruction word, zero-extended. Delegation, handler entry and CSR storage live outside this block.

Top module: `vtrap_classifier`

## Requirements
- R1: A counter CSR access (0xC00–0xC1F, counter index = address bits 4:0) from S or U level whose machine counter-enable bit is 0 raises an illegal fault (cause 2), whatever the guest bit and hypervisor counter-enable bit are.
- R2: A counter access from a guest (virt=1, priv S or U) whose machine bit is 1 and hypervisor bit is 0 raises a virtual fault (cause 22). With both bits 1, or from M level, there is no fault.
- R3: Class HVMEM (code 3, guest-memory load/store) raises a virtual fault for any guest below M. Outside a guest it raises an illegal fault at U level and no fault at S or M level.
- R4: Class HFENCE (code 4), or access to a hypervisor-level CSR (address bits 9:8 = 2), raises a virtual fault in guest-supervisor mode and an illegal fault at U level, guest or not. It raises no fault at host S or at M level.
- R5: Class SRET (code 5) raises an illegal fault at U level. In guest-supervisor mode it raises a virtual fault when the hypervisor SRET-trap bit is 1. At host S it raises an illegal fault when the machine SRET-trap bit is 1.
- R6: Class SFENCE (code 6), and access to the address-translation CSR 0x180, raise an illegal fault at U level. In guest-supervisor mode they raise a virtual fault when the hypervisor VM-trap bit is 1. At host S they raise an illegal fault when the machine VM-trap bit is 1.
- R7: A WFI (code 2) held below M level is timed when the machine wait-trap bit is 1, or when virt=1 and the hypervisor wait-trap bit is 1. Counting from 0 in its first cycle, the fault fires in the cycle where the number of completed stall cycles equals wfi_limit. The fault is illegal when the machine bit is set, because that bit takes precedence, and virtual otherwise. An untimed WFI never faults.
- R8: A cycle with irq_wake high gives no WFI fault, and the stall count restarts from 0 afterwards.
- R9: With virt=0, or at M level, no virtual fault is ever raised.
- R10: On a fault, trap_tval is insn_bits zero-extended to XLEN. Without a fault, trap_valid, trap_cause and trap_tval are 0.
- R11: A machine-level CSR (address bits 9:8 = 3) accessed below M, a supervisor-level CSR (bits 9:8 = 1) accessed at U level, and class BAD (code 7) all raise an illegal fault.
- R12: With insn_valid low, or for class OTHER (code 0), no fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_valid | input | 1 | An instruction occupies the stage |
| insn_class | input | 3 | 0 OTHER, 1 CSR, 2 WFI, 3 HVMEM, 4 HFENCE, 5 SRET, 6 SFENCE, 7 BAD |
| insn_bits | input | ILEN | Raw instruction word |
| csr_addr | input | 12 | CSR number for class CSR |
| virt | input | 1 | Guest (virtualization) bit |
| priv | input | 2 | Privilege level: 0 U, 1 S, 3 M |
| mcnt_en | input | 32 | Machine counter-enable mask |
| hcnt_en | input | 32 | Hypervisor counter-enable mask |
| m_tw | input | 1 | Machine wait-trap bit |
| m_tsr | input | 1 | Machine SRET-trap bit |
| m_tvm | input | 1 | Machine VM-trap bit |
| h_vtw | input | 1 | Hypervisor wait-trap bit |
| h_vtsr | input | 1 | Hypervisor SRET-trap bit |
| h_vtvm | input | 1 | Hypervisor VM-trap bit |
| wfi_limit | input | CNT_W | Allowed WFI stall cycles |
| irq_wake | input | 1 | A pending enabled interrupt wakes the hart |
| trap_valid | output | 1 | Fault raised this cycle |
| trap_cause | output | CAUSE_W | 2 illegal, 22 virtual, 0 none |
| trap_tval | output | XLEN | Value for the trap-value CSR |
| wfi_hold | output | 1 | WFI must keep stalling |

## Verification
The assertions assume that priv never takes the reserved value 2 and that wfi_limit stays constant while a WFI is held. The random phase draws priv only from {0,1,3} and keeps the WFI class out of the draw. The WFI sequences load the limit before the wait starts and leave it unchanged until the wait has been withdrawn. The assertions also assume that insn_bits, class and mode stay steady within a cycle. The bench meets this by changing them only at the falling edge.

// File: rtl/vtrap_pkg.sv
package vtrap_pkg;

   typedef enum logic [2:0] {
      IC_OTHER  = 3'd0,
      IC_CSR    = 3'd1,
      IC_WFI    = 3'd2,
      IC_HVMEM  = 3'd3,
      IC_HFENCE = 3'd4,
      IC_SRET   = 3'd5,
      IC_SFENCE = 3'd6,
      IC_BAD    = 3'd7
   } iclass_e;

   typedef enum logic [1:0] {
      VD_NONE = 2'd0,
      VD_ILL  = 2'd1,
      VD_VIRT = 2'd2
   } verdict_e;

   localparam logic [1:0] LVL_U = 2'd0;
   localparam logic [1:0] LVL_S = 2'd1;
   localparam logic [1:0] LVL_M = 2'd3;

   localparam int unsigned CODE_ILLEGAL = 2;
   localparam int unsigned CODE_VIRTUAL = 22;

   localparam logic [11:0] ADDR_XLATE   = 12'h180;
   localparam logic [6:0]  CNT_BLOCK_LO = 7'b1100000;
   localparam logic [6:0]  CNT_BLOCK_HI = 7'b1100100;

endpackage

// File: rtl/vtrap_csr_check.sv
module vtrap_csr_check
   import vtrap_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [11:0] csr_addr,
   input  logic        guest,
   input  logic [1:0]  priv,
   input  logic [31:0] mcnt_en,
   input  logic [31:0] hcnt_en,
   input  logic        m_tvm,
   input  logic        h_vtvm,
   output verdict_e    verdict
);

   localparam int IDX_W = 5;

   logic             in_cnt_block;
   logic [IDX_W-1:0] cnt_idx;
   logic [1:0]       need_lvl;
   logic             below_m;

   assign cnt_idx  = csr_addr[IDX_W-1:0];
   assign need_lvl = csr_addr[9:8];
   assign below_m  = (priv != LVL_M);

   generate
      if (XLEN == 32) begin : g_hi_half
         assign in_cnt_block = (csr_addr[11:5] == CNT_BLOCK_LO) ||
                               (csr_addr[11:5] == CNT_BLOCK_HI);
      end else begin : g_lo_only
         assign in_cnt_block = (csr_addr[11:5] == CNT_BLOCK_LO);
      end
   endgenerate

   always_comb begin
      verdict = VD_NONE;
      if (in_cnt_block) begin
         if (below_m && !mcnt_en[cnt_idx])
            verdict = VD_ILL;
         else if (guest && !hcnt_en[cnt_idx])
            verdict = VD_VIRT;
      end else begin
         unique case (need_lvl)
            2'd3: if (below_m) verdict = VD_ILL;
            2'd2: begin
               if (priv == LVL_U)      verdict = VD_ILL;
               else if (guest)         verdict = VD_VIRT;
            end
            2'd1: begin
               if (priv == LVL_U)      verdict = VD_ILL;
               else if (csr_addr == ADDR_XLATE && priv == LVL_S) begin
                  if (guest) begin
                     if (h_vtvm)       verdict = VD_VIRT;
                  end else if (m_tvm)  verdict = VD_ILL;
               end
            end
            default: verdict = VD_NONE;
         endcase
      end
   end

endmodule

// File: rtl/vtrap_sys_check.sv
module vtrap_sys_check
   import vtrap_pkg::*;
(
   input  iclass_e    iclass,
   input  logic       guest,
   input  logic [1:0] priv,
   input  logic       m_tsr,
   input  logic       m_tvm,
   input  logic       h_vtsr,
   input  logic       h_vtvm,
   output verdict_e   verdict
);

   logic at_u, at_s;
   assign at_u = (priv == LVL_U);
   assign at_s = (priv == LVL_S);

   function automatic verdict_e ctl_rule(input logic g, input logic s,
                                         input logic u, input logic hbit,
                                         input logic mbit);
      verdict_e r;
      r = VD_NONE;
      if (u)            r = VD_ILL;
      else if (s && g)  r = hbit ? VD_VIRT : VD_NONE;
      else if (s)       r = mbit ? VD_ILL : VD_NONE;
      return r;
   endfunction

   always_comb begin
      verdict = VD_NONE;
      unique case (iclass)
         IC_HVMEM: begin
            if (guest)      verdict = VD_VIRT;
            else if (at_u)  verdict = VD_ILL;
         end
         IC_HFENCE: begin
            if (at_u)               verdict = VD_ILL;
            else if (guest && at_s) verdict = VD_VIRT;
         end
         IC_SRET:   verdict = ctl_rule(guest, at_s, at_u, h_vtsr, m_tsr);
         IC_SFENCE: verdict = ctl_rule(guest, at_s, at_u, h_vtvm, m_tvm);
         IC_BAD:    verdict = VD_ILL;
         default:   verdict = VD_NONE;
      endcase
   end

endmodule

// File: rtl/vtrap_wfi_timer.sv
module vtrap_wfi_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wfi_req,
   input  logic             timed,
   input  logic             irq_wake,
   input  logic [CNT_W-1:0] limit,
   output logic             expire,
   output logic             hold
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic             running;

   assign running = wfi_req && timed && !irq_wake;
   assign expire  = running && (cnt_q == limit);
   assign hold    = wfi_req && !irq_wake && !expire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!running || expire)
         cnt_q <= '0;
      else if (cnt_q != CNT_MAX)
         cnt_q <= cnt_q + 1'b1;
   end

   AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(irq_wake) |-> cnt_q == '0); // R8

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (running && $stable(limit) && $past(running)) |-> cnt_q <= limit); // R7

endmodule

// File: rtl/vtrap_classifier.sv
module vtrap_classifier
   import vtrap_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int ILEN    = 32,
   parameter int CNT_W   = 8,
   parameter int CAUSE_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               insn_valid,
   input  logic [2:0]         insn_class,
   input  logic [ILEN-1:0]    insn_bits,
   input  logic [11:0]        csr_addr,
   input  logic               virt,
   input  logic [1:0]         priv,
   input  logic [31:0]        mcnt_en,
   input  logic [31:0]        hcnt_en,
   input  logic               m_tw,
   input  logic               m_tsr,
   input  logic               m_tvm,
   input  logic               h_vtw,
   input  logic               h_vtsr,
   input  logic               h_vtvm,
   input  logic [CNT_W-1:0]   wfi_limit,
   input  logic               irq_wake,
   output logic               trap_valid,
   output logic [CAUSE_W-1:0] trap_cause,
   output logic [XLEN-1:0]    trap_tval,
   output logic               wfi_hold
);

   localparam int TVAL_PAD = XLEN - ILEN;
   localparam logic [CAUSE_W-1:0] C_ILL  = CAUSE_W'(CODE_ILLEGAL);
   localparam logic [CAUSE_W-1:0] C_VIRT = CAUSE_W'(CODE_VIRTUAL);

   initial begin
      if (XLEN != 32 && XLEN != 64) $error("XLEN must be 32 or 64");
      if (ILEN < 16 || ILEN > XLEN) $error("ILEN out of range");
      if (CNT_W < 1)                $error("CNT_W too small");
      if (CAUSE_W < 5)              $error("CAUSE_W cannot hold 22");
   end

   iclass_e  cls;
   logic     guest;
   verdict_e csr_vd, sys_vd, wfi_vd, final_vd;
   logic     wfi_req, wfi_timed, wfi_expire;

   assign cls   = iclass_e'(insn_class);
   assign guest = virt && (priv != LVL_M);

   vtrap_csr_check #(.XLEN(XLEN)) u_csr (
      .csr_addr (csr_addr),
      .guest    (guest),
      .priv     (priv),
      .mcnt_en  (mcnt_en),
      .hcnt_en  (hcnt_en),
      .m_tvm    (m_tvm),
      .h_vtvm   (h_vtvm),
      .verdict  (csr_vd)
   );

   vtrap_sys_check u_sys (
      .iclass  (cls),
      .guest   (guest),
      .priv    (priv),
      .m_tsr   (m_tsr),
      .m_tvm   (m_tvm),
      .h_vtsr  (h_vtsr),
      .h_vtvm  (h_vtvm),
      .verdict (sys_vd)
   );

   assign wfi_req   = insn_valid && (cls == IC_WFI);
   assign wfi_timed = (priv != LVL_M) && (m_tw || (guest && h_vtw));

   vtrap_wfi_timer #(.CNT_W(CNT_W)) u_wfi (
      .clk      (clk),
      .rst_n    (rst_n),
      .wfi_req  (wfi_req),
      .timed    (wfi_timed),
      .irq_wake (irq_wake),
      .limit    (wfi_limit),
      .expire   (wfi_expire),
      .hold     (wfi_hold)
   );

   always_comb begin
      wfi_vd = VD_NONE;
      if (wfi_expire) wfi_vd = m_tw ? VD_ILL : VD_VIRT;
   end

   always_comb begin
      final_vd = VD_NONE;
      if (insn_valid) begin
         unique case (cls)
            IC_CSR:  final_vd = csr_vd;
            IC_WFI:  final_vd = wfi_vd;
            default: final_vd = sys_vd;
         endcase
      end
   end

   generate
      if (TVAL_PAD > 0) begin : g_pad
         assign trap_tval = (final_vd != VD_NONE) ?
                            {{TVAL_PAD{1'b0}}, insn_bits} : '0;
      end else begin : g_nopad
         assign trap_tval = (final_vd != VD_NONE) ? insn_bits : '0;
      end
   endgenerate

   assign trap_valid = (final_vd != VD_NONE);
   assign trap_cause = (final_vd == VD_ILL)  ? C_ILL  :
                       (final_vd == VD_VIRT) ? C_VIRT : '0;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_valid |-> !trap_valid); // R12

   AST_VIRT_ONLY_GUEST: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && trap_cause == C_VIRT) |-> (virt && priv != LVL_M)); // R9

   AST_TVAL_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> trap_tval[ILEN-1:0] == insn_bits); // R10

   AST_MCNT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && cls == IC_CSR && csr_addr[11:5] == CNT_BLOCK_LO &&
       priv != LVL_M && !mcnt_en[csr_addr[4:0]])
      |-> (trap_valid && trap_cause == C_ILL)); // R1

   AST_WAKE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && cls == IC_WFI && irq_wake) |-> !trap_valid); // R8

   AST_QUIET_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && cls == IC_OTHER) |-> !trap_valid); // R12

endmodule

// File: tb/tb_vtrap_classifier.sv
module tb_vtrap_classifier;

   localparam int CLK_PERIOD = 10;
   localparam int XLEN = 64, ILEN = 32, CNT_W = 8, CAUSE_W = 6;

   logic clk = 0, rst_n = 0;
   logic insn_valid = 0;
   logic [2:0] insn_class = 0;
   logic [ILEN-1:0] insn_bits = 0;
   logic [11:0] csr_addr = 0;
   logic virt = 0;
   logic [1:0] priv = 0;
   logic [31:0] mcnt_en = 0, hcnt_en = 0;
   logic m_tw = 0, m_tsr = 0, m_tvm = 0, h_vtw = 0, h_vtsr = 0, h_vtvm = 0;
   logic [CNT_W-1:0] wfi_limit = 0;
   logic irq_wake = 0;
   logic trap_valid;
   logic [CAUSE_W-1:0] trap_cause;
   logic [XLEN-1:0] trap_tval;
   logic wfi_hold;

   int total = 0, bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vtrap_classifier #(.XLEN(XLEN), .ILEN(ILEN), .CNT_W(CNT_W), .CAUSE_W(CAUSE_W)) dut (
      .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_class(insn_class),
      .insn_bits(insn_bits), .csr_addr(csr_addr), .virt(virt), .priv(priv),
      .mcnt_en(mcnt_en), .hcnt_en(hcnt_en), .m_tw(m_tw), .m_tsr(m_tsr),
      .m_tvm(m_tvm), .h_vtw(h_vtw), .h_vtsr(h_vtsr), .h_vtvm(h_vtvm),
      .wfi_limit(wfi_limit), .irq_wake(irq_wake), .trap_valid(trap_valid),
      .trap_cause(trap_cause), .trap_tval(trap_tval), .wfi_hold(wfi_hold));

   // expected kind: 0 none, 1 illegal (cause 2), 2 virtual (cause 22)
   function automatic int model(input int cls, input logic [11:0] a, input logic v,
                                input logic [1:0] p, input logic [31:0] mc,
                                input logic [31:0] hc);
      bit g;
      g = v && (p != 2'd3);
      case (cls)
         1: begin
            if (a[11:5] == 7'h60) begin
               if (p != 2'd3 && mc[a[4:0]] == 1'b0) return 1;
               if (g && hc[a[4:0]] == 1'b0) return 2;
               return 0;
            end
            if (a[9:8] == 2'd3) return (p == 2'd3) ? 0 : 1;
            if (a[9:8] == 2'd2) begin
               if (p == 2'd0) return 1;
               return g ? 2 : 0;
            end
            if (a[9:8] == 2'd1) begin
               if (p == 2'd0) return 1;
               if (a == 12'h180 && p == 2'd1) return v ? (h_vtvm ? 2 : 0) : (m_tvm ? 1 : 0);
            end
            return 0;
         end
         3: return g ? 2 : (p == 2'd0 ? 1 : 0);
         4: return (p == 2'd0) ? 1 : ((g && p == 2'd1) ? 2 : 0);
         5: return (p == 2'd0) ? 1 : (p == 2'd1 ? (v ? (h_vtsr ? 2 : 0) : (m_tsr ? 1 : 0)) : 0);
         6: return (p == 2'd0) ? 1 : (p == 2'd1 ? (v ? (h_vtvm ? 2 : 0) : (m_tvm ? 1 : 0)) : 0);
         7: return 1;
         default: return 0;
      endcase
   endfunction

   function automatic string tag_of(input int cls, input logic [11:0] a,
                                    input logic [1:0] p, input logic [31:0] mc);
      case (cls)
         1: begin
            if (a[11:5] == 7'h60) return (p != 2'd3 && !mc[a[4:0]]) ? "R1" : "R2";
            if (a == 12'h180) return "R6";
            if (a[9:8] == 2'd2) return "R4";
            return "R11";
         end
         3: return "R3";
         4: return "R4";
         5: return "R5";
         6: return "R6";
         7: return "R11";
         default: return "R12";
      endcase
   endfunction

   task automatic check(input string req, input int kind);
      logic [CAUSE_W-1:0] ec;
      logic [XLEN-1:0] et;
      logic ev;
      ev = (kind != 0);
      ec = (kind == 1) ? CAUSE_W'(2) : (kind == 2) ? CAUSE_W'(22) : '0;
      et = ev ? {{(XLEN-ILEN){1'b0}}, insn_bits} : '0;
      total++;
      if (trap_valid !== ev || trap_cause !== ec || trap_tval !== et) begin
         bad++;
         $display("FAIL %s: got valid=%0b cause=%0d tval=%h, expected valid=%0b cause=%0d tval=%h",
                  req, trap_valid, trap_cause, trap_tval, ev, ec, et);
      end
   endtask

   task automatic put(input int cls, input logic [11:0] a, input logic v, input logic [1:0] p);
      @(negedge clk);
      insn_valid = 1; insn_class = 3'(cls); csr_addr = a; virt = v; priv = p;
      insn_bits = $urandom;
      #1;
   endtask

   task automatic tick;
      @(negedge clk); #1;
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      total++; bad++;
      $display("FAIL watchdog: got running, expected finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      #(CLK_PERIOD * 3);
      #1;
      check("R10", 0);                 // reset state: quiet outputs
      rst_n = 1;

      // R12: idle with a BAD class pending
      @(negedge clk); insn_valid = 0; insn_class = 3'd7; insn_bits = 32'hdead_beef; #1;
      check("R12", 0);

      // R1: machine bit clear wins over hypervisor bit
      mcnt_en = 32'h0; hcnt_en = 32'hffff_ffff;
      put(1, 12'hC02, 1, 1); check("R1", 1);
      put(1, 12'hC02, 0, 0); check("R1", 1);
      // R2
      mcnt_en = 32'hffff_ffff; hcnt_en = 32'hffff_fffb;
      put(1, 12'hC02, 1, 0); check("R2", 2);
      put(1, 12'hC01, 1, 1); check("R2", 0);
      put(1, 12'hC02, 1, 3); check("R2", 0);
      // R9: host modes never virtual
      put(3, 12'h0, 0, 1);   check("R9", 0);
      put(3, 12'h0, 1, 3);   check("R9", 0);
      put(4, 12'h0, 0, 1);   check("R9", 0);
      put(1, 12'h600, 0, 1); check("R9", 0);
      // R4/R11
      put(1, 12'h200, 1, 1); check("R4", 2);
      put(1, 12'h200, 1, 0); check("R4", 1);
      put(1, 12'h300, 1, 1); check("R11", 1);
      put(1, 12'h100, 0, 0); check("R11", 1);
      // R5/R6
      h_vtsr = 1; m_tsr = 0;
      put(5, 12'h0, 1, 1); check("R5", 2);
      put(5, 12'h0, 0, 1); check("R5", 0);
      h_vtvm = 0; m_tvm = 1;
      put(1, 12'h180, 0, 1); check("R6", 1);
      put(1, 12'h180, 1, 1); check("R6", 0);

      // random phase
      for (int i = 0; i < 400; i++) begin
         int cls, pick;
         logic [11:0] a;
         logic [1:0] p;
         cls = $urandom_range(0, 7);
         if (cls == 2) cls = 1;
         pick = $urandom_range(0, 6);
         case (pick)
            0: a = 12'hC00 | 12'($urandom_range(0, 31));
            1: a = 12'h180;
            2: a = 12'h600 | 12'($urandom_range(0, 255));
            3: a = 12'h300 | 12'($urandom_range(0, 255));
            4: a = 12'h100 | 12'($urandom_range(0, 63));
            5: a = 12'h001;
            default: a = 12'h200 | 12'($urandom_range(0, 255));
         endcase
         p = 2'($urandom_range(0, 2));
         if (p == 2'd2) p = 2'd3;
         mcnt_en = $urandom; hcnt_en = $urandom;
         m_tsr = 1'($urandom); m_tvm = 1'($urandom);
         h_vtsr = 1'($urandom); h_vtvm = 1'($urandom);
         put(cls, a, 1'($urandom), p);
         check(tag_of(cls, a, p, mcnt_en), model(cls, a, virt, p, mcnt_en, hcnt_en));
      end

      // R7: guest wait trap, limit 3 -> virtual at count 3
      @(negedge clk); insn_valid = 0; m_tw = 0; h_vtw = 1; wfi_limit = 3;
      put(2, 12'h0, 1, 1); check("R7", 0);
      tick(); check("R7", 0);
      tick(); check("R7", 0);
      tick(); check("R7", 2);
      @(negedge clk); insn_valid = 0;
      // R7: machine bit takes precedence, limit 1
      m_tw = 1; wfi_limit = 1;
      put(2, 12'h0, 1, 1); check("R7", 0);
      tick(); check("R7", 1);
      @(negedge clk); insn_valid = 0;
      // R7: limit 0 fires at once
      wfi_limit = 0;
      put(2, 12'h0, 0, 0); check("R7", 1);
      @(negedge clk); insn_valid = 0;
      // R7: untimed wait never faults
      m_tw = 0; h_vtw = 1;
      put(2, 12'h0, 0, 1);
      for (int k = 0; k < 6; k++) begin check("R7", 0); tick(); end
      @(negedge clk); insn_valid = 0;
      // R8: wake then restart from zero
      h_vtw = 1; wfi_limit = 4;
      put(2, 12'h0, 1, 1); check("R8", 0);
      tick(); check("R8", 0);
      tick(); check("R8", 0);
      @(negedge clk); irq_wake = 1; #1; check("R8", 0);
      @(negedge clk); irq_wake = 0; #1;
      for (int k = 0; k < 4; k++) begin check("R8", 0); tick(); end
      check("R8", 2);
      @(negedge clk); insn_valid = 0;

      tick();
      finish_run();
   end

endmodule